// File: doc/BRIEF.md
# Chain Tile Return-Link Responder

This block is the return-path logic of one tile in a clocked daisy chain. While it has nothing to report, the return data arriving from the next tile down the chain reaches the upstream output through a plain multiplexer, with no register in the path. Edges of any rate therefore pass through unchanged. In the same mode the link clock is forwarded to the downstream tile.

Local logic hands bytes to the block through a small push-style queue. Once a burst of pushes ends, the block takes over the upstream line and sends each queued byte as a 10-bit frame, one bit per rising link-clock edge. Frames follow one another with no gap. While it is sending, the downstream clock is stopped through a glitch-free latch gate. The line is handed back to passthrough, and the clock restarts, only after the last stop bit.

Top module: `link_return_path`

## Requirements
- R1: While `busy_o` is low, `up_data_o` equals `dn_data_i` combinationally, including changes of `dn_data_i` between clock edges.
- R2: Each queued byte is sent as a 10-bit frame: first a start bit of value 0, then 8 data bits, then a stop bit of value 1. `up_data_o` presents one bit per rising edge of `clk_i`.
- R3: Data bits go out least significant bit first, so byte 0x5C appears as 0,0,0,1,1,1,0,1,0,1.
- R4: When several bytes are queued, their frames follow back to back with no idle bit between them.
- R5: While idle, `dn_clk_o` follows `clk_i`. From the second clock high phase of a transmission until the first high phase after `busy_o` falls, `dn_clk_o` stays low. The clock runs again from the next high phase.
- R6: `busy_o` rises at the edge that drives the first start bit. It falls only at the edge that ends the last stop bit, so a partial frame is never driven.
- R7: While `busy_o` is high, `full_o` is high and a push is ignored. Such a byte is never sent.
- R8: A push is accepted on a rising edge where `push_i` is high and `full_o` is low. Transmission starts at the first edge where the queue holds data and either `push_i` is low or the queue is full. Pushes beyond `FIFO_DEPTH` (default 4) are dropped.
- R9: After a synchronous active-low reset, `busy_o` is low, the queue is empty and the block is in passthrough.
- R10: The clock-gate enable changes only while `clk_i` is low, so the high pulse in progress when a transmission starts is delivered in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock from upstream |
| rst_n_i | input | 1 | Synchronous active-low reset |
| dn_data_i | input | 1 | Return data from the downstream tile |
| push_i | input | 1 | Request to queue one byte |
| push_byte_i | input | 8 | Byte to queue |
| full_o | output | 1 | High when a push would be ignored (queue full or busy) |
| up_data_o | output | 1 | Return data toward upstream |
| dn_clk_o | output | 1 | Gated link clock toward the downstream tile |
| busy_o | output | 1 | High while the block drives its own frames |

## Verification
A single 0x5C frame checks the start and stop bits and the bit order, because its wire pattern is not symmetric. A three-byte burst with differing values checks that frames join with no gap and that each byte is framed on its own. Five pushes into a four-entry queue check the launch on a full queue and the dropped fifth byte. A push made in the middle of a frame, followed by a quiet line with the downstream data held at 0, shows that the ignored byte never appears. It also shows that the line returns to passthrough rather than staying at the idle-high level. Toggling the downstream data between clock edges tells a combinational path apart from a sampled one. Sampling the gated clock in each high phase checks both the completed first pulse and the suppressed ones.

// File: rtl/link_rp_pkg.sv
// Shared constants and types for the chain return-link responder.
package link_rp_pkg;
    localparam int BYTE_W     = 8;
    localparam int FRAME_BITS = BYTE_W + 2;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/link_byte_fifo.sv
// Byte queue feeding the framer.
// Assumes: a push while full is dropped, and a pop while empty is ignored.
// Pointers wrap explicitly, so any depth of 2 or more works.
module link_byte_fifo
    import link_rp_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                       clk_i,
    input  logic                       rst_n_i,
    input  logic                       push_i,
    input  byte_t                      data_i,
    input  logic                       pop_i,
    output byte_t                      head_o,
    output logic                       empty_o,
    output logic                       full_o,
    output logic [$clog2(DEPTH+1)-1:0] level_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    byte_t              store_q [DEPTH];
    logic [PTR_W-1:0]   wr_ptr_q;
    logic [PTR_W-1:0]   rd_ptr_q;
    logic [CNT_W-1:0]   count_q;
    logic               do_push;
    logic               do_pop;

    // Qualify the requests against the fill level.
    always_comb begin
        do_push = push_i && (count_q != CNT_W'(DEPTH));
        do_pop  = pop_i  && (count_q != '0);
    end

    // Write the storage on an accepted push.
    always_ff @(posedge clk_i) begin
        if (do_push) store_q[wr_ptr_q] <= data_i;
    end

    // Advance the pointers and track the fill level.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push)
                wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH-1)) ? '0 : wr_ptr_q + 1'b1;
            if (do_pop)
                rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH-1)) ? '0 : rd_ptr_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assign head_o  = store_q[rd_ptr_q];
    assign empty_o = (count_q == '0);
    assign full_o  = (count_q == CNT_W'(DEPTH));
    assign level_o = count_q;

    // R8: the fill level never exceeds the queue depth.
    assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        count_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/link_frame_tx.sv
// Serialiser for the return link: start bit 0, data bits LSB first,
// stop bit 1, one bit per rising clock edge.
// Assumes: byte_i is valid whenever have_byte_i is high, and pop_o takes it.
// A new frame is loaded at the stop-bit edge of the previous one when data
// is waiting, so consecutive frames carry no gap.
module link_frame_tx
    import link_rp_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_n_i,
    input  logic  launch_ok_i,
    input  logic  have_byte_i,
    input  byte_t byte_i,
    output logic  pop_o,
    output logic  line_o,
    output logic  active_o
);
    logic [FRAME_BITS-1:0] shift_q;
    logic [IDX_W-1:0]      idx_q;
    logic                  active_q;
    logic                  last_bit;
    logic                  load;

    // Decide when the next frame is loaded.
    always_comb begin
        last_bit = (idx_q == IDX_W'(FRAME_BITS-1));
        load     = have_byte_i && (active_q ? last_bit : launch_ok_i);
    end

    // Shift the frame out and track the bit position.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            active_q <= 1'b0;
            shift_q  <= '1;
            idx_q    <= '0;
        end else if (load) begin
            active_q <= 1'b1;
            shift_q  <= {1'b1, byte_i, 1'b0};
            idx_q    <= '0;
        end else if (active_q) begin
            if (last_bit) begin
                active_q <= 1'b0;
                shift_q  <= '1;
                idx_q    <= '0;
            end else begin
                shift_q  <= {1'b1, shift_q[FRAME_BITS-1:1]};
                idx_q    <= idx_q + 1'b1;
            end
        end
    end

    assign pop_o    = load;
    assign line_o   = shift_q[0];
    assign active_o = active_q;

    // R2: the first bit of every frame is a 0.
    assert_start_bit_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (active_q && idx_q == '0) |-> !line_o);
    // R2: the last bit of every frame is a 1.
    assert_stop_bit_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (active_q && last_bit) |-> line_o);
    // R6: the framer releases the line only after a stop bit.
    assert_release_on_boundary_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $fell(active_q) |-> $past(idx_q) == IDX_W'(FRAME_BITS-1));
endmodule

// File: rtl/link_clk_gate.sv
// Glitch-free clock gate for the downstream link clock.
// The enable is captured by a latch that is open only while the clock is
// low, so it cannot cut or stretch a high pulse already in progress.
module link_clk_gate (
    input  logic clk_i,
    input  logic en_i,
    output logic gclk_o
);
    logic en_lat;

    // Hold the enable steady through each high phase.
    always_latch begin
        if (!clk_i) en_lat = en_i;
    end

    assign gclk_o = clk_i & en_lat;
endmodule

// File: rtl/link_return_path.sv
// Return path of one chain tile. Forwards downstream return data to the
// upstream output through a combinational mux and forwards the link clock
// downstream. When queued bytes are waiting, it takes the line and sends
// them as back-to-back frames, with the downstream clock stopped.
// Assumes: the differential buffers and command decoding sit outside.
module link_return_path
    import link_rp_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              dn_data_i,
    input  logic              push_i,
    input  logic [BYTE_W-1:0] push_byte_i,
    output logic              full_o,
    output logic              up_data_o,
    output logic              dn_clk_o,
    output logic              busy_o
);
    localparam int CNT_W = $clog2(FIFO_DEPTH+1);

    byte_t            head;
    logic             q_empty;
    logic             q_full;
    logic             q_pop;
    logic [CNT_W-1:0] q_level;
    logic             tx_line;
    logic             tx_active;
    logic             push_ok;
    logic             launch_ok;

    // Gate pushes with the busy state and pick the launch moment.
    always_comb begin
        push_ok   = push_i && !tx_active;
        launch_ok = !push_i || q_full;
    end

    link_byte_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .push_i  (push_ok),
        .data_i  (push_byte_i),
        .pop_i   (q_pop),
        .head_o  (head),
        .empty_o (q_empty),
        .full_o  (q_full),
        .level_o (q_level)
    );

    link_frame_tx framer_i (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .launch_ok_i (launch_ok),
        .have_byte_i (!q_empty),
        .byte_i      (head),
        .pop_o       (q_pop),
        .line_o      (tx_line),
        .active_o    (tx_active)
    );

    link_clk_gate gate_i (
        .clk_i  (clk_i),
        .en_i   (!tx_active),
        .gclk_o (dn_clk_o)
    );

    // Select the upstream source: the framer while sending, else passthrough.
    always_comb begin
        up_data_o = tx_active ? tx_line : dn_data_i;
    end

    assign busy_o = tx_active;
    assign full_o = q_full || tx_active;

    // R7: no byte enters the queue while frames are being sent.
    assert_no_push_when_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        busy_o |=> q_level <= $past(q_level));
    // R8: a transmission never starts with an empty queue.
    assert_launch_has_data_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(busy_o) |-> $past(!q_empty));
endmodule

// File: tb/link_return_path_tb_top.sv
// Directed bench for link_return_path: one task per scenario.
module link_return_path_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dn_data = 1'b0;
    logic       push = 1'b0;
    logic [7:0] push_byte = 8'h00;
    logic       full, up_data, dn_clk, busy;

    int n_checks = 0;
    int n_errors = 0;
    logic [7:0] q [8];

    always #5 clk = ~clk;

    link_return_path dut_i (
        .clk_i       (clk),
        .rst_n_i     (rst_n),
        .dn_data_i   (dn_data),
        .push_i      (push),
        .push_byte_i (push_byte),
        .full_o      (full),
        .up_data_o   (up_data),
        .dn_clk_o    (dn_clk),
        .busy_o      (busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // R9: reset state.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        dn_data = 1'b0;
        #1;
        chk(busy == 1'b0, "R9", "busy after reset", busy, 0);
        chk(full == 1'b0, "R9", "full after reset", full, 0);
        chk(up_data == 1'b0, "R9", "passthrough after reset", up_data, 0);
    endtask

    // R1 and R5: combinational passthrough and a free-running clock while idle.
    task automatic t_passthrough();
        @(negedge clk);
        for (int k = 0; k < 6; k++) begin
            dn_data = k[0];
            #1;
            chk(up_data == dn_data, "R1", "passthrough mid-cycle", up_data, dn_data);
        end
        @(posedge clk); #2;
        chk(dn_clk == 1'b1, "R5", "idle clock high phase", dn_clk, 1);
        @(negedge clk); #2;
        chk(dn_clk == 1'b0, "R5", "idle clock low phase", dn_clk, 0);
    endtask

    // Push, then check every bit, the gated clock and the return to passthrough.
    task automatic run_frames(input int nframes, input int npush, input bit inject,
                              input string req);
        int total;
        int b, j;
        logic exp_bit;
        total = nframes * 10;
        for (int k = 0; k < npush; k++) begin
            @(negedge clk);
            push = 1'b1;
            push_byte = q[k];
            @(posedge clk);
        end
        if (npush <= 4) begin
            @(negedge clk);
            push = 1'b0;
            @(posedge clk);
        end
        // At the edge that drives the start bit (E0).
        for (int i = 0; i < total; i++) begin
            #2;
            if (i == 0)
                chk(dn_clk == 1'b1, "R10", "first pulse completes", dn_clk, 1);
            else
                chk(dn_clk == 1'b0, "R5", "clock stopped while sending", dn_clk, 0);
            @(negedge clk);
            push = (inject && i == 3);
            push_byte = 8'hA5;
            b = i / 10;
            j = i % 10;
            exp_bit = (j == 0) ? 1'b0 : (j == 9) ? 1'b1 : q[b][j-1];
            chk(up_data == exp_bit, req, $sformatf("frame %0d bit %0d", b, j),
                up_data, exp_bit);
            chk(busy == 1'b1, "R6", "busy during frames", busy, 1);
            chk(full == 1'b1, "R7", "full while busy", full, 1);
            @(posedge clk);
        end
        push = 1'b0;
        dn_data = 1'b0;
        #2;
        chk(dn_clk == 1'b0, "R5", "gate still closed at release edge", dn_clk, 0);
        @(negedge clk);
        chk(busy == 1'b0, "R6", "busy drops after last stop bit", busy, 1'b0);
        @(posedge clk); #2;
        chk(dn_clk == 1'b1, "R5", "clock resumes", dn_clk, 1);
        // Quiet period: a stray or dropped byte would show up here.
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            chk(busy == 1'b0, "R7", "no extra frame", busy, 0);
            chk(up_data == 1'b0, "R1", "line back in passthrough", up_data, 0);
        end
    endtask

    // R2, R3: one frame of 0x5C.
    task automatic t_single();
        q[0] = 8'h5C;
        run_frames(1, 1, 1'b0, "R3");
    endtask

    // R4: three frames back to back.
    task automatic t_burst();
        q[0] = 8'h81; q[1] = 8'h3C; q[2] = 8'hF0;
        run_frames(3, 3, 1'b0, "R4");
    endtask

    // R7: a push in mid-frame is ignored.
    task automatic t_ignore_busy();
        q[0] = 8'h12;
        run_frames(1, 1, 1'b1, "R7");
    endtask

    // R8: a full queue launches, and the fifth push is dropped.
    task automatic t_overflow();
        q[0] = 8'h01; q[1] = 8'h80; q[2] = 8'hAA; q[3] = 8'h55; q[4] = 8'hFF;
        run_frames(4, 5, 1'b0, "R8");
    endtask

    // Stimulus sequence.
    initial begin
        t_reset();
        t_passthrough();
        t_single();
        t_burst();
        t_ignore_busy();
        t_overflow();
        t_reset();
        t_passthrough();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    // Watchdog: counts as a failed check if the run hangs.
    initial begin
        #1000000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule